// File: doc/BRIEF.md
# Page-Mode Parallel ROM Read Controller

This block is the host side of a read path to an external parallel ROM. The ROM has a 21-bit word address, a pin that selects a 16-bit word or 8-bit byte data width, and a page-mode fast path. The controller accepts one read at a time on a valid/ready interface. Each request carries a byte address and a byte-mode flag. The controller drives the chip-enable, output-enable, address and width-select pins, counts a fixed number of clock cycles, and then samples the data lines. It returns the result as a single-cycle response pulse.

A page is eight consecutive words. The controller remembers which page, and which width mode, the previous access used, as long as the chip has stayed enabled since then. A read that lands in that page waits only the short page-access time. Any other read waits the full random-access time. In byte mode the top data pin of the ROM becomes an address input, and the controller drives the least significant byte-address bit onto it. After a run of idle cycles the controller deselects the chip to put it in standby, and it forgets the open page.

All delays are given in nanoseconds and converted to whole clock cycles by rounding up. The output-enable access time is folded into both wait lengths.

Top module: `prom_rd_ctrl`

## Requirements
- R1: While reset is applied and just after it, rom_ce_n and rom_oe_n are 1, req_ready is 1 and rsp_valid is 0.
- R2: The first read after reset is a random access. rsp_valid rises exactly W_RAND = max(ceil(T_RAND_NS/CLK_NS), ceil(T_OE_NS/CLK_NS)) cycles after the accepting edge, which is 10 cycles with the defaults. The returned data equals the ROM contents.
- R3: When a read has the same word-address bits [20:3] and the same width mode as the previous read, and the chip has not been deselected in between, rsp_valid rises exactly W_PAGE = max(ceil(T_PAGE_NS/CLK_NS), ceil(T_OE_NS/CLK_NS)) cycles after acceptance (3 by default). This includes a repeat read of the same word.
- R4: A read whose word-address bits [20:3] differ from those of the previous read takes W_RAND cycles.
- R5: In word mode (req_byte = 0) the controller drives rom_byte_n = 1, rom_addr = req_addr[21:1] and rom_lsb_oe = 0, and rsp_data equals all 16 bits of rom_dq. In word mode req_addr[0] is ignored.
- R6: In byte mode (req_byte = 1) the controller drives rom_byte_n = 0, rom_addr = req_addr[21:1], rom_lsb = req_addr[0] and rom_lsb_oe = 1, and rsp_data = {8'h00, rom_dq[7:0]}.
- R7: A read whose width mode differs from the previous read takes W_RAND cycles, even when the page is the same.
- R8: After IDLE_CYC idle cycles with the chip selected, rom_ce_n goes to 1 (standby). The next read then takes W_RAND cycles, even within the old page. Short idle gaps leave rom_ce_n at 0.
- R9: req_ready is 1 only when no read is in flight. A request presented while busy is ignored, and rom_addr, rom_byte_n and rom_lsb hold steady during an access. rsp_valid lasts exactly one cycle.
- R10: rom_oe_n is 0 exactly while a read is in flight and returns to 1 on the response cycle. rom_oe_n = 0 never occurs with rom_ce_n = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W+1 | Byte address; bits [ADDR_W:1] are the word address |
| req_byte | input | 1 | 1 = byte-wide read, 0 = word read |
| rsp_valid | output | 1 | One-cycle pulse, rsp_data is valid |
| rsp_data | output | 2*BYTE_W | Read data, zero-extended in byte mode |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_byte_n | output | 1 | ROM width select, 0 = byte mode |
| rom_addr | output | ADDR_W | ROM word address |
| rom_lsb | output | 1 | Byte-address LSB for the top data pin |
| rom_lsb_oe | output | 1 | Drive enable for rom_lsb onto the top data pin |
| rom_dq | input | 2*BYTE_W | ROM data lines |

## Verification
The assertions check a set of properties on every cycle. Output-enable is never active without chip-enable. Output-enable stays active for the whole time the controller is busy. The pins stay stable during an access. Responses last one cycle and are never returned before the short page wait. Byte-mode results have a zero upper byte. Standby happens only while the controller is ready. Whether a given read was a page hit and took the short wait, or was a miss and took the full wait, depends on the history of earlier reads. Only the bench can show this, and it does so with a ROM model that returns inverted data until its own delay has passed. The byte-lane routing and the standby timing are also shown only by the bench's sweeps.

// File: rtl/prom_pkg.sv
package prom_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } prom_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prom_rst_sync.sv
module prom_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/prom_page_track.sv
module prom_page_track #(
  parameter int TAG_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             update,
  input  logic             invalidate,
  output logic             hit
);

  logic             valid_q, valid_d;
  logic [TAG_W-1:0] tag_q;

  always_comb begin
    valid_d = valid_q;
    if (update) begin
      valid_d = 1'b1;
    end else if (invalidate) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (update) begin
        tag_q <= tag_in;
      end
    end
  end

  assign hit = valid_q && (tag_q == tag_in);

endmodule

// File: rtl/prom_wait_timer.sv
module prom_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/prom_idle_timer.sv
module prom_idle_timer #(
  parameter int IDLE_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  localparam int CW = $clog2(IDLE_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expire = run && (cnt_q == CW'(IDLE_CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run || expire) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/prom_lane_fmt.sv
module prom_lane_fmt #(
  parameter int BYTE_W = 8
) (
  input  logic [2*BYTE_W-1:0] dq,
  input  logic                byte_mode,
  output logic [2*BYTE_W-1:0] data
);

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    if (lane == 0) begin : g_low
      assign data[lane*BYTE_W +: BYTE_W] = dq[lane*BYTE_W +: BYTE_W];
    end else begin : g_high
      assign data[lane*BYTE_W +: BYTE_W] =
        byte_mode ? '0 : dq[lane*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/prom_rd_ctrl.sv
module prom_rd_ctrl #(
  parameter int ADDR_W    = 21,
  parameter int PAGE_W    = 3,
  parameter int BYTE_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_RAND_NS = 100,
  parameter int T_PAGE_NS = 30,
  parameter int T_OE_NS   = 30,
  parameter int IDLE_CYC  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W:0]     req_addr,
  input  logic                req_byte,
  output logic                rsp_valid,
  output logic [2*BYTE_W-1:0] rsp_data,
  output logic                rom_ce_n,
  output logic                rom_oe_n,
  output logic                rom_byte_n,
  output logic [ADDR_W-1:0]   rom_addr,
  output logic                rom_lsb,
  output logic                rom_lsb_oe,
  input  logic [2*BYTE_W-1:0] rom_dq
);

  import prom_pkg::*;

  localparam int DW       = 2 * BYTE_W;
  localparam int RAND_CYC = ceil_div(T_RAND_NS, CLK_NS);
  localparam int PAGE_CYC = ceil_div(T_PAGE_NS, CLK_NS);
  localparam int OE_CYC   = ceil_div(T_OE_NS, CLK_NS);
  localparam int W_RAND   = max_i(max_i(RAND_CYC, OE_CYC), 1);
  localparam int W_PAGE   = max_i(max_i(PAGE_CYC, OE_CYC), 1);
  localparam int CNT_W    = max_i($clog2(W_RAND + 1), 1);
  localparam int TAG_W    = ADDR_W - PAGE_W + 1;

  logic rst_sync_n;

  prom_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  prom_state_e           state_q, state_d;
  logic                  ce_n_q, ce_n_d;
  logic                  oe_n_q, oe_n_d;
  logic                  byte_n_q, byte_n_d;
  logic                  lsb_q, lsb_d;
  logic [ADDR_W-1:0]     addr_q, addr_d;
  logic                  rsp_v_q, rsp_v_d;
  logic [DW-1:0]         data_q;
  logic                  cap_en;

  logic                  accept;
  logic                  page_hit;
  logic                  idle_expire;
  logic                  tmr_zero;
  logic [CNT_W-1:0]      wait_val;
  logic [TAG_W-1:0]      tag_in;
  logic [DW-1:0]         fmt_data;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign tag_in    = {req_byte, req_addr[ADDR_W:PAGE_W+1]};
  assign wait_val  = page_hit ? CNT_W'(W_PAGE - 1) : CNT_W'(W_RAND - 1);

  prom_page_track #(.TAG_W(TAG_W)) u_page (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tag_in    (tag_in),
    .update    (accept),
    .invalidate(idle_expire),
    .hit       (page_hit)
  );

  prom_wait_timer #(.CNT_W(CNT_W)) u_wait (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (accept),
    .load_val(wait_val),
    .zero    (tmr_zero)
  );

  prom_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (req_ready && !ce_n_q && !accept),
    .expire(idle_expire)
  );

  prom_lane_fmt #(.BYTE_W(BYTE_W)) u_fmt (
    .dq       (rom_dq),
    .byte_mode(!byte_n_q),
    .data     (fmt_data)
  );

  always_comb begin
    state_d  = state_q;
    ce_n_d   = ce_n_q;
    oe_n_d   = oe_n_q;
    byte_n_d = byte_n_q;
    lsb_d    = lsb_q;
    addr_d   = addr_q;
    rsp_v_d  = 1'b0;
    cap_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d  = ST_WAIT;
          ce_n_d   = 1'b0;
          oe_n_d   = 1'b0;
          addr_d   = req_addr[ADDR_W:1];
          byte_n_d = !req_byte;
          lsb_d    = req_byte && req_addr[0];
        end else if (idle_expire) begin
          ce_n_d = 1'b1;
        end
      end
      ST_WAIT: begin
        if (tmr_zero) begin
          state_d = ST_IDLE;
          oe_n_d  = 1'b1;
          rsp_v_d = 1'b1;
          cap_en  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      ce_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      byte_n_q <= 1'b1;
      lsb_q    <= 1'b0;
      addr_q   <= '0;
      rsp_v_q  <= 1'b0;
      data_q   <= '0;
    end else begin
      state_q  <= state_d;
      ce_n_q   <= ce_n_d;
      oe_n_q   <= oe_n_d;
      byte_n_q <= byte_n_d;
      lsb_q    <= lsb_d;
      addr_q   <= addr_d;
      rsp_v_q  <= rsp_v_d;
      if (cap_en) begin
        data_q <= fmt_data;
      end
    end
  end

  assign rsp_valid  = rsp_v_q;
  assign rsp_data   = data_q;
  assign rom_ce_n   = ce_n_q;
  assign rom_oe_n   = oe_n_q;
  assign rom_byte_n = byte_n_q;
  assign rom_addr   = addr_q;
  assign rom_lsb    = lsb_q;
  assign rom_lsb_oe = !byte_n_q;

endmodule

// File: rtl/prom_rd_ctrl_chk.sv
module prom_rd_ctrl_chk #(
  parameter int ADDR_W   = 21,
  parameter int DW       = 16,
  parameter int WAIT_MIN = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [DW-1:0]     rsp_data,
  input logic              rom_ce_n,
  input logic              rom_oe_n,
  input logic              rom_byte_n,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              rom_lsb
);

  logic [7:0] oe_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_low_cnt <= '0;
    end else if (rom_oe_n) begin
      oe_low_cnt <= '0;
    end else if (oe_low_cnt != 8'hFF) begin
      oe_low_cnt <= oe_low_cnt + 1'b1;
    end
  end

  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> !rom_ce_n); // R10

  AST_BUSY_OE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !rom_oe_n); // R10

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9

  AST_PINS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |->
      ($stable(rom_addr) && $stable(rom_byte_n) && $stable(rom_lsb))); // R9

  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rom_byte_n) |-> (rsp_data[DW-1:DW/2] == '0)); // R6

  AST_STANDBY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rom_ce_n |-> req_ready); // R8

  AST_MIN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (oe_low_cnt >= 8'(WAIT_MIN))); // R3

endmodule

bind prom_rd_ctrl prom_rd_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .DW      (DW),
  .WAIT_MIN(W_PAGE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .rom_ce_n  (rom_ce_n),
  .rom_oe_n  (rom_oe_n),
  .rom_byte_n(rom_byte_n),
  .rom_addr  (rom_addr),
  .rom_lsb   (rom_lsb)
);

// File: tb/prom_rd_ctrl_tb.sv
`timescale 1ns/1ps
module prom_rd_ctrl_tb;

  localparam int AW    = 21;
  localparam int IDLE  = 32;
  localparam int MR    = ((100 + 9) / 10 > (30 + 9) / 10) ? (100 + 9) / 10 : (30 + 9) / 10;
  localparam int MP    = ((30 + 9) / 10 > (30 + 9) / 10) ? (30 + 9) / 10 : (30 + 9) / 10;
  localparam int LONG  = IDLE + 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW:0]   req_addr;
  logic          req_byte;
  logic          rsp_valid;
  logic [15:0]   rsp_data;
  logic          rom_ce_n, rom_oe_n, rom_byte_n, rom_lsb, rom_lsb_oe;
  logic [AW-1:0] rom_addr;
  logic [15:0]   rom_dq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  prom_rd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .rom_byte_n(rom_byte_n), .rom_addr(rom_addr), .rom_lsb(rom_lsb),
    .rom_lsb_oe(rom_lsb_oe), .rom_dq(rom_dq)
  );

  function automatic logic [15:0] fdat(input logic [AW-1:0] w);
    logic [31:0] t;
    t = {11'd0, w} * 32'h0000_9E37;
    return t[15:0] ^ t[31:16] ^ 16'hC3A5;
  endfunction

  // Behavioural ROM: data turns correct only after its own delay has passed.
  logic [24:0] m_prev;
  int          m_age, m_need;
  logic [17:0] m_pg;
  logic        m_mode, m_ov;

  always @(negedge clk) begin : rom_model
    logic [24:0] snap;
    logic [15:0] good;
    logic        hit;
    snap = {rom_ce_n, rom_oe_n, rom_byte_n, rom_lsb, rom_addr};
    if (rom_ce_n) begin
      m_ov  = 1'b0;
      m_age = 0;
    end else if (snap != m_prev) begin
      hit    = m_ov && (rom_addr[20:3] == m_pg) && (rom_byte_n == m_mode);
      m_need = hit ? MP : MR;
      m_ov   = 1'b1;
      m_pg   = rom_addr[20:3];
      m_mode = rom_byte_n;
      m_age  = 0;
    end else if (m_age < 1000) begin
      m_age++;
    end
    m_prev = snap;
    good   = fdat(rom_addr);
    if (rom_ce_n || rom_oe_n) begin
      rom_dq = 'z;
    end else begin
      if (m_age + 1 < m_need) good = ~good;
      rom_dq = rom_byte_n ? good : {8'hzz, (rom_lsb ? good[15:8] : good[7:0])};
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Bench-side record of the open page
  logic        e_v = 1'b0;
  logic [17:0] e_pg;
  logic        e_bm;
  bit          first = 1'b1;

  task automatic rd(input logic [AW:0] ba, input logic bm, input int gap, input bit poke);
    int    k;
    int    exp_lat;
    string tag;
    logic [15:0] w, exp_d;
    repeat (gap) @(negedge clk);
    if (gap >= LONG) begin
      chk(rom_ce_n == 1'b1, "R8", "standby after idle", rom_ce_n, 1);
      e_v = 1'b0;
      tag = "R8";
    end else if (!first) begin
      chk(rom_ce_n == 1'b0, "R8", "no early standby", rom_ce_n, 0);
    end
    if (e_v && e_pg == ba[AW:4] && e_bm == bm) begin
      exp_lat = MP; tag = "R3";
    end else begin
      exp_lat = MR;
      if (first) tag = "R2";
      else if (gap >= LONG) tag = "R8";
      else if (e_v && e_pg == ba[AW:4]) tag = "R7";
      else tag = "R4";
    end
    chk(req_ready == 1'b1, "R9", "ready when idle", req_ready, 1);
    req_valid = 1'b1; req_addr = ba; req_byte = bm;
    @(posedge clk);
    @(negedge clk);
    k = 0;
    req_valid = 1'b0;
    chk(!rom_ce_n && !rom_oe_n, "R10", "enables low in access", {rom_ce_n, rom_oe_n}, 0);
    chk(rom_addr == ba[AW:1], bm ? "R6" : "R5", "rom_addr", rom_addr, ba[AW:1]);
    chk(rom_byte_n == !bm, bm ? "R6" : "R5", "width pin", rom_byte_n, !bm);
    chk(rom_lsb_oe == bm && (!bm || rom_lsb == ba[0]), bm ? "R6" : "R5", "lsb pin",
        {rom_lsb_oe, rom_lsb}, {bm, bm & ba[0]});
    if (poke) begin
      chk(req_ready == 1'b0, "R9", "busy not ready", req_ready, 0);
      req_valid = 1'b1; req_addr = ~ba; req_byte = bm;
    end
    while (!rsp_valid && k < 40) begin
      @(negedge clk);
      k++;
      if (poke && k == 1) begin
        chk(rom_addr == ba[AW:1], "R9", "busy request ignored", rom_addr, ba[AW:1]);
        req_valid = 1'b0;
      end
    end
    chk(k == exp_lat, tag, "latency", k, exp_lat);
    w     = fdat(ba[AW:1]);
    exp_d = bm ? {8'h00, (ba[0] ? w[15:8] : w[7:0])} : w;
    chk(rsp_data == exp_d, bm ? "R6" : "R5", "data", rsp_data, exp_d);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9", "single-cycle response", rsp_valid, 0);
    chk(rom_oe_n == 1'b1, "R10", "oe released", rom_oe_n, 1);
    e_v = 1'b1; e_pg = ba[AW:4]; e_bm = bm; first = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [AW:0] base;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_byte = 1'b0;
    repeat (4) @(negedge clk);
    chk(rom_ce_n && rom_oe_n && req_ready && !rsp_valid, "R1", "reset state",
        {rom_ce_n, rom_oe_n, req_ready, rsp_valid}, 4'b1110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rom_ce_n && rom_oe_n && req_ready && !rsp_valid, "R1", "after reset",
        {rom_ce_n, rom_oe_n, req_ready, rsp_valid}, 4'b1110);

    // Word sweep of one page, then several pages with varying gaps
    for (int p = 0; p < 6; p++) begin
      base = {(21'h0ABC0 + 21'(p * 8 * (p + 1))), 1'b0};
      for (int wd = 0; wd < 8; wd++)
        rd(base + 22'(wd * 2) + 22'(wd & 1), 1'b0, wd % 3, (wd == 0));
    end
    rd(22'h15780E, 1'b0, 0, 1'b0);         // repeat-ish same page
    rd(22'h15780E, 1'b0, 1, 1'b0);         // same word again
    rd(22'h000000, 1'b0, 0, 1'b0);         // far page
    rd({21'h1FFFFF, 1'b0}, 1'b0, 2, 1'b0); // top word
    rd({21'h1FFFF8, 1'b1}, 1'b0, 0, 1'b0); // same top page

    // Byte mode: all 16 bytes of a page, then back to word mode
    base = 22'h024680;
    for (int b = 0; b < 16; b++) rd(base + 22'(b), 1'b1, b % 2, 1'b0);
    rd(base + 22'd4, 1'b0, 0, 1'b0);
    rd(base + 22'd5, 1'b1, 0, 1'b0);

    // Standby after a long idle, then same page again
    rd(base + 22'd6, 1'b1, LONG, 1'b0);
    rd(base + 22'd7, 1'b1, 0, 1'b0);
    rd(22'h3FFFF0, 1'b0, LONG, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule